// File: doc/BRIEF.md
# Per-Pin Interrupt and Wake Event Detector

This block watches one already-debounced GPIO input and turns activity on it into two sticky status flags: an interrupt flag and a wake flag. A small per-pin control word chooses edge or level sensing, the active polarity (high/rising, low/falling, or either edge), whether interrupt events are recorded at all, whether a recorded interrupt is forwarded, and in which of the low-power states a detected event counts as a wake. Software clears either flag by writing one to it, which appears at this block as a single-cycle clear pulse.

The block has two small state machines. The sensing FSM has the states ARMING and TRACKING. ARMING holds for the first clock after reset, so that the unknown earlier level is never taken as an edge. It moves to TRACKING unconditionally on the next clock, and stays in TRACKING until reset. Each status flag has its own FSM with the states CLEAR and SET. The transition CLEAR to SET is taken on a qualified event. SET to CLEAR is taken on a clear pulse only when no event arrives in the same cycle. Otherwise each state holds. The flag outputs go to an aggregator outside this block, which collects the pins together.

Top module: `pin_evt_detector`

## Requirements
- R1: After reset int_sts, wake_sts, int_req and pending are 0. The first clock edge after reset is never treated as an input edge, whatever level the pin has.
- R2: With cfg_level_trig=0 (edge sensing), cfg_polarity=2'b00 records a 0-to-1 change of pin_lvl and cfg_polarity=2'b01 records a 1-to-0 change. An edge is found by comparing pin_lvl with its value sampled on the previous clock.
- R3: cfg_polarity=2'b10 records both edges when edge sensing is selected, and records nothing in level mode. cfg_polarity=2'b11 records nothing in either mode.
- R4: With cfg_level_trig=1, polarity 2'b00 records an event on every clock where pin_lvl is 1, and polarity 2'b01 does so where pin_lvl is 0. The flag therefore sets again right after a clear while the level persists.
- R5: Events are recorded into int_sts only while cfg_int_en is 1. With cfg_int_en=0, int_sts does not change to 1.
- R6: int_req is 1 exactly when int_sts is 1 and cfg_int_unmask is 1. Masking with cfg_int_unmask=0 does not clear int_sts.
- R7: A one-cycle pulse on clr_int clears int_sts on the next clock. If an event qualifies in that same cycle, the event wins and int_sts stays 1.
- R8: pwr_state 0 is the running state and never records a wake. pwr_state k (1 to 3) records a detected event into wake_sts only when wake_en bit k-1 is 1. This is independent of cfg_int_en and cfg_int_unmask.
- R9: clr_wake clears wake_sts with the same rules as R7: write-one semantics, and the event wins over a clear in the same cycle.
- R10: pending is 1 whenever int_sts or wake_sts is 1.
- R11: A status flag reads 1 starting from the clock edge at which the triggering pin level is first sampled. There is one register stage between input and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_lvl | input | 1 | Debounced pin level |
| cfg_level_trig | input | 1 | 0 selects edge sensing, 1 selects level sensing |
| cfg_polarity | input | 2 | 00 high/rising, 01 low/falling, 10 both edges, 11 none |
| cfg_int_en | input | 1 | Record interrupt events |
| cfg_int_unmask | input | 1 | 1 forwards int_sts onto int_req |
| cfg_wake_en | input | N_LP_STATES (3) | Bit k-1 enables wake in power state k |
| pwr_state | input | PS_W (2) | 0 running, 1..N_LP_STATES low-power states |
| clr_int | input | 1 | Write-one-to-clear pulse for int_sts |
| clr_wake | input | 1 | Write-one-to-clear pulse for wake_sts |
| int_sts | output | 1 | Sticky interrupt status |
| wake_sts | output | 1 | Sticky wake status |
| int_req | output | 1 | Masked interrupt request |
| pending | output | 1 | Interrupt or wake status set |

## Verification
The bench releases reset while the pin is high and a rising edge is configured. A design that compares against a reset value instead of arming would raise a spurious interrupt here. It sends a clear in the same cycle as a fresh edge, and a clear while a level stays active. A design that lets the clear win would drop a real event, and in level mode would show a one-cycle gap. It sweeps every power state against every wake-enable pattern, with interrupts disabled. This exposes a wake qualification that is off by one or that depends on the interrupt enable. It also drives polarity 10 in level mode and 11 in both modes, to catch decoders that treat the reserved codes as active.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    // Polarity select codes
    typedef enum logic [1:0] {
        POL_HIGH = 2'b00,
        POL_LOW  = 2'b01,
        POL_BOTH = 2'b10,
        POL_NONE = 2'b11
    } pol_e;

    // Sensing FSM: first sample after reset is not compared
    typedef enum logic {
        SNS_ARMING   = 1'b0,
        SNS_TRACKING = 1'b1
    } sns_state_e;

    // Sticky flag FSM
    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flg_state_e;

endpackage

// File: rtl/pin_evt_sense.sv
module pin_evt_sense
    import pin_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_lvl,
    input  logic       trig_level,
    input  logic [1:0] polarity,
    output logic       hit
);

    sns_state_e state_q;
    sns_state_e state_d;
    logic       prev_q;
    logic       edge_ok;
    logic       rise;
    logic       fall;
    pol_e       pol;

    assign pol = pol_e'(polarity);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SNS_ARMING;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= pin_lvl;
        end
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        edge_ok = 1'b0;
        unique case (state_q)
            SNS_ARMING: begin
                state_d = SNS_TRACKING;
                edge_ok = 1'b0;
            end
            SNS_TRACKING: begin
                state_d = SNS_TRACKING;
                edge_ok = 1'b1;
            end
        endcase
    end

    assign rise = edge_ok &  pin_lvl & ~prev_q;
    assign fall = edge_ok & ~pin_lvl &  prev_q;

    always_comb begin
        hit = 1'b0;
        if (trig_level) begin
            unique case (pol)
                POL_HIGH: hit = pin_lvl;
                POL_LOW:  hit = ~pin_lvl;
                POL_BOTH: hit = 1'b0;
                POL_NONE: hit = 1'b0;
            endcase
        end else begin
            unique case (pol)
                POL_HIGH: hit = rise;
                POL_LOW:  hit = fall;
                POL_BOTH: hit = rise | fall;
                POL_NONE: hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pin_evt_flag.sv
module pin_evt_flag
    import pin_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flg_state_e state_q;
    flg_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // A new event outranks a clear in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: if (set_i) state_d = FLG_SET;
            FLG_SET:   if (clr_i && !set_i) state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_CLEAR: flag_o = 1'b0;
            FLG_SET:   flag_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pin_evt_wake_qual.sv
module pin_evt_wake_qual #(
    parameter int N_LP_STATES = 3,
    parameter int PS_W        = $clog2(N_LP_STATES + 1)
) (
    input  logic [PS_W-1:0]        pwr_state,
    input  logic [N_LP_STATES-1:0] wake_en,
    output logic                   allowed
);

    logic [N_LP_STATES-1:0] match;

    for (genvar k = 0; k < N_LP_STATES; k++) begin : g_state
        localparam logic [PS_W-1:0] CODE = PS_W'(k + 1);
        assign match[k] = (pwr_state == CODE) & wake_en[k];
    end

    assign allowed = |match;

endmodule

// File: rtl/pin_evt_detector.sv
module pin_evt_detector #(
    parameter int N_LP_STATES = 3,
    parameter int PS_W        = $clog2(N_LP_STATES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pin_lvl,
    input  logic                   cfg_level_trig,
    input  logic [1:0]             cfg_polarity,
    input  logic                   cfg_int_en,
    input  logic                   cfg_int_unmask,
    input  logic [N_LP_STATES-1:0] cfg_wake_en,
    input  logic [PS_W-1:0]        pwr_state,
    input  logic                   clr_int,
    input  logic                   clr_wake,
    output logic                   int_sts,
    output logic                   wake_sts,
    output logic                   int_req,
    output logic                   pending
);

    logic hit;
    logic wake_ok;

    pin_evt_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl    (pin_lvl),
        .trig_level (cfg_level_trig),
        .polarity   (cfg_polarity),
        .hit        (hit)
    );

    pin_evt_wake_qual #(
        .N_LP_STATES (N_LP_STATES),
        .PS_W        (PS_W)
    ) u_wake_qual (
        .pwr_state (pwr_state),
        .wake_en   (cfg_wake_en),
        .allowed   (wake_ok)
    );

    pin_evt_flag u_int_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit & cfg_int_en),
        .clr_i  (clr_int),
        .flag_o (int_sts)
    );

    pin_evt_flag u_wake_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit & wake_ok),
        .clr_i  (clr_wake),
        .flag_o (wake_sts)
    );

    assign int_req = int_sts & cfg_int_unmask;
    assign pending = int_sts | wake_sts;

endmodule

// File: rtl/pin_evt_detector_chk.sv
module pin_evt_detector_chk #(
    parameter int N_LP_STATES = 3,
    parameter int PS_W        = $clog2(N_LP_STATES + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pin_lvl,
    input logic                   cfg_level_trig,
    input logic [1:0]             cfg_polarity,
    input logic                   cfg_int_en,
    input logic                   cfg_int_unmask,
    input logic [N_LP_STATES-1:0] cfg_wake_en,
    input logic [PS_W-1:0]        pwr_state,
    input logic                   clr_int,
    input logic                   clr_wake,
    input logic                   int_sts,
    input logic                   wake_sts,
    input logic                   int_req,
    input logic                   pending
);

    a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_sts) |-> $past(cfg_int_en));

    a_r7_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (int_sts && !clr_int) |=> int_sts);

    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (int_sts && clr_int && !cfg_int_en) |=> !int_sts);

    a_r9_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sts && !clr_wake) |=> wake_sts);

    a_r8_wake_lowpower: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_sts) |-> ($past(pwr_state) != '0 && $past(cfg_wake_en) != '0));

    a_r4_level_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level_trig && cfg_int_en && cfg_polarity == 2'b00 && pin_lvl) |=> int_sts);

    a_r3_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_sts && cfg_polarity == 2'b11) |=> !int_sts);

    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_int_unmask |-> !int_req);

    a_r10_pending_cover: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> !int_req);

endmodule

bind pin_evt_detector pin_evt_detector_chk #(
    .N_LP_STATES (N_LP_STATES),
    .PS_W        (PS_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pin_lvl        (pin_lvl),
    .cfg_level_trig (cfg_level_trig),
    .cfg_polarity   (cfg_polarity),
    .cfg_int_en     (cfg_int_en),
    .cfg_int_unmask (cfg_int_unmask),
    .cfg_wake_en    (cfg_wake_en),
    .pwr_state      (pwr_state),
    .clr_int        (clr_int),
    .clr_wake       (clr_wake),
    .int_sts        (int_sts),
    .wake_sts       (wake_sts),
    .int_req        (int_req),
    .pending        (pending)
);

// File: tb/test_pin_evt_detector.sv
`timescale 1ns/1ps
module test_pin_evt_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_lvl = 1'b0;
    logic       cfg_level_trig = 1'b0;
    logic [1:0] cfg_polarity = 2'b00;
    logic       cfg_int_en = 1'b0;
    logic       cfg_int_unmask = 1'b0;
    logic [2:0] cfg_wake_en = 3'b000;
    logic [1:0] pwr_state = 2'b00;
    logic       clr_int = 1'b0;
    logic       clr_wake = 1'b0;
    logic       int_sts, wake_sts, int_req, pending;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model state
    bit m_armed = 0, m_prev = 0, m_int = 0, m_wake = 0;

    always #2 clk = ~clk;

    pin_evt_detector i_pin_evt_detector (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl),
        .cfg_level_trig(cfg_level_trig), .cfg_polarity(cfg_polarity),
        .cfg_int_en(cfg_int_en), .cfg_int_unmask(cfg_int_unmask),
        .cfg_wake_en(cfg_wake_en), .pwr_state(pwr_state),
        .clr_int(clr_int), .clr_wake(clr_wake),
        .int_sts(int_sts), .wake_sts(wake_sts),
        .int_req(int_req), .pending(pending)
    );

    // Behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        bit ev, wk_ok;
        if (!rst_n) begin
            m_armed = 0; m_prev = 0; m_int = 0; m_wake = 0;
        end else begin
            ev = 0;
            if (cfg_level_trig) begin
                if (cfg_polarity == 2'd0) ev = pin_lvl;
                if (cfg_polarity == 2'd1) ev = !pin_lvl;
            end else if (m_armed) begin
                if (cfg_polarity == 2'd0) ev = pin_lvl && !m_prev;
                if (cfg_polarity == 2'd1) ev = !pin_lvl && m_prev;
                if (cfg_polarity == 2'd2) ev = pin_lvl != m_prev;
            end
            wk_ok = (pwr_state != 0) && cfg_wake_en[pwr_state - 1];
            if (ev && cfg_int_en) m_int = 1; else if (clr_int) m_int = 0;
            if (ev && wk_ok) m_wake = 1; else if (clr_wake) m_wake = 0;
            m_prev = pin_lvl;
            m_armed = 1;
        end
    end

    task automatic cmp(input string what, input bit got, input bit exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        cmp("int_sts",  int_sts,  m_int);
        cmp("wake_sts", wake_sts, m_wake);
        cmp("int_req",  int_req,  m_int && cfg_int_unmask);
        cmp("pending",  pending,  m_int || m_wake);
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            clr_int = 0;
            clr_wake = 0;
        end
    endtask

    initial begin
        // R1: release reset with pin high and rising-edge sensing armed
        cur_req = "R1";
        pin_lvl = 1; cfg_int_en = 1; cfg_int_unmask = 1; cfg_polarity = 2'b00;
        tick(3);
        rst_n = 1;
        tick(3);
        cmp("R1 no edge on first sample", int_sts, 1'b0);

        // R2 / R11: rising and falling edges
        cur_req = "R2";
        pin_lvl = 0; tick(2);
        pin_lvl = 1; tick(1);
        cmp("R11 flag one edge after sample", int_sts, 1'b1);
        clr_int = 1; tick(2);
        cfg_polarity = 2'b01; pin_lvl = 0; tick(2);
        cmp("R2 falling sets", int_sts, 1'b1);
        clr_int = 1; tick(1);
        pin_lvl = 1; tick(2);

        // R6: mask keeps status
        cur_req = "R6";
        cfg_int_unmask = 0; pin_lvl = 0; tick(2);
        cmp("R6 masked req", int_req, 1'b0);
        cmp("R6 status kept", int_sts, 1'b1);
        cfg_int_unmask = 1; tick(1);
        cmp("R6 unmasked req", int_req, 1'b1);

        // R7: clear together with a new edge
        cur_req = "R7";
        pin_lvl = 1; tick(1);
        pin_lvl = 0; clr_int = 1; tick(1);
        cmp("R7 event beats clear", int_sts, 1'b1);
        clr_int = 1; tick(2);

        // R3: both edges, reserved code, both-edge code in level mode
        cur_req = "R3";
        cfg_polarity = 2'b10;
        pin_lvl = 1; tick(1); clr_int = 1; tick(1);
        pin_lvl = 0; tick(1); clr_int = 1; tick(1);
        cfg_polarity = 2'b11;
        for (int i = 0; i < 4; i++) begin pin_lvl = ~pin_lvl; tick(1); end
        cmp("R3 reserved edge", int_sts, 1'b0);
        cfg_level_trig = 1; cfg_polarity = 2'b10;
        for (int i = 0; i < 4; i++) begin pin_lvl = ~pin_lvl; tick(1); end
        cfg_polarity = 2'b11; tick(3);
        cmp("R3 level mode reserved", int_sts, 1'b0);

        // R4: level sensing re-asserts after clear
        cur_req = "R4";
        cfg_polarity = 2'b00; pin_lvl = 1; tick(2);
        clr_int = 1; tick(1);
        cmp("R4 reasserted", int_sts, 1'b1);
        cfg_polarity = 2'b01; pin_lvl = 0; tick(2);
        pin_lvl = 1; clr_int = 1; tick(2);

        // R5: disabled interrupts record nothing
        cur_req = "R5";
        cfg_int_en = 0; cfg_level_trig = 0; cfg_polarity = 2'b10;
        for (int i = 0; i < 6; i++) begin pin_lvl = ~pin_lvl; tick(1); end
        cfg_level_trig = 1; cfg_polarity = 2'b00; pin_lvl = 1; tick(3);
        cmp("R5 disabled", int_sts, 1'b0);

        // R8 / R9 / R10: wake across all states and enable patterns
        cur_req = "R8";
        cfg_level_trig = 0; cfg_polarity = 2'b10;
        for (int ps = 0; ps < 4; ps++) begin
            for (int we = 0; we < 8; we++) begin
                pwr_state = 2'(ps); cfg_wake_en = 3'(we);
                pin_lvl = ~pin_lvl; tick(1);
                cmp("R10 pending follows wake", pending, m_wake);
                cur_req = "R9";
                clr_wake = 1; pin_lvl = ~pin_lvl; tick(1);
                clr_wake = 1; tick(1);
                cur_req = "R8";
            end
        end
        pwr_state = 2'd2; cfg_wake_en = 3'b010;
        pin_lvl = ~pin_lvl; tick(1);
        cmp("R8 wake state 2", wake_sts, 1'b1);
        cmp("R10 pending", pending, 1'b1);
        cur_req = "R9";
        pin_lvl = ~pin_lvl; clr_wake = 1; tick(1);
        cmp("R9 event beats clear", wake_sts, 1'b1);
        clr_wake = 1; tick(2);
        cmp("R9 cleared", wake_sts, 1'b0);

        // R7 again with interrupts on and wake off
        cur_req = "R7";
        cfg_int_en = 1; cfg_wake_en = 0;
        for (int i = 0; i < 10; i++) begin
            pin_lvl = ~pin_lvl;
            clr_int = (i % 3 == 0);
            tick(1);
        end
        tick(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule